// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous memory of 18-bit words for cache data storage. Every input except the output enable is captured in an input register on the rising clock edge. The captured command runs during the following cycle, and read data lands in an output register one edge later. So each rising edge presents the result of the access that the previous edge captured. The output enable gates the data bus asynchronously. The bus has three states and is modelled as `dout` plus a drive qualifier `dout_en`.

An access sequence starts on one of two strobes. `proc_start` is meant for a processor and always reads. `ctrl_start` is meant for a cache controller and may also write. Either strobe loads the external address. A 2-bit beat counter then produces the rest of a four-word burst. The counter steps only when `advance` is high, and it walks the aligned group of four in interleaved order: the low two address bits are the starting low bits XOR the beat count. Each half of the word has its own write enable. The depth is set by `ADDR_W`. The default is 10, giving 1,024 words, and 16 gives 65,536.

Top module: `psb_sram`

## Requirements
- R1: After reset `dout_en` is 0 and no access sequence is selected. A cycle with no start strobe performs no write, even when both write enables and `chip_en` are high.
- R2: A read whose inputs are captured at rising edge N has its word on `dout` after rising edge N+1. `dout_en` then follows `out_en` until the output register changes.
- R3: `ctrl_start` with `chip_en` high loads `addr`. The cycle writes the lanes whose enables are high, and it reads when neither enable is high.
- R4: `proc_start` with `chip_en` high takes priority over `ctrl_start`, loads `addr` and always reads. The write enables and `din` have no effect in that cycle.
- R5: In a burst cycle without a strobe, the beat count steps by one when `advance` is high. The accessed address keeps the upper bits of the loaded address, and its low two bits are the loaded low two bits XOR the beat count. The count wraps to 0 after beat 3, so the fifth beat returns to the start word. `addr` is ignored in these cycles.
- R6: A burst cycle with no strobe and `advance` low accesses the same word again.
- R7: `wr_lo` writes bits 8:0 and `wr_hi` writes bits 17:9, each independently. A write cycle does not load the output register, and `dout_en` is 0 after it.
- R8: `dout_en` follows `out_en` combinationally with no clock edge, while the output register holds read data.
- R9: `proc_start` is ignored while `chip_en` is low. `ctrl_start` with `chip_en` low ends the sequence, and the cycles after it without a strobe perform no access, so no write happens and `dout_en` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address, used by a start strobe |
| din | input | 18 | Write data |
| proc_start | input | 1 | Processor start strobe: loads address, read only |
| ctrl_start | input | 1 | Controller start strobe: loads address, read or write |
| advance | input | 1 | Steps the beat counter in burst cycles |
| wr_lo | input | 1 | Write enable for bits 8:0 |
| wr_hi | input | 1 | Write enable for bits 17:9 |
| chip_en | input | 1 | Chip enable, registered |
| out_en | input | 1 | Asynchronous output enable |
| dout | output | 18 | Registered read data |
| dout_en | output | 1 | Bus drive qualifier |

## Verification
A command driven before rising edge N is captured at N, and it is executed and written into the array at edge N+1. Read data is therefore due on `dout` after edge N+1. A write shows its effect only through a later read, which follows the same two-edge rule. The bench drives inputs at falling edges. It checks each step's result at the falling edge two steps later, and a behavioural model checks the expected output register on every clock. The output-enable checks toggle `out_en` between edges and sample a few nanoseconds later, with no edge in between.

// File: rtl/psb_sram_pkg.sv
package psb_sram_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    // Interleaved order: low address bits of a beat are start XOR count.
    function automatic beat_t beat_offset(beat_t start, beat_t beat);
        return start ^ beat;
    endfunction

endpackage

// File: rtl/psb_burst.sv
module psb_burst
    import psb_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps,
    input  logic              cs,
    input  logic              adv,
    input  logic              wl,
    input  logic              wh,
    input  logic              ce,
    input  logic [ADDR_W-1:0] a,
    output logic              acc_valid,
    output logic              acc_rd,
    output logic              acc_wl,
    output logic              acc_wh,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int GRP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] base;
        beat_t             cnt;
    } bst_t;

    bst_t  st_d, st_q;
    logic  p_go;
    beat_t step;

    always_comb begin
        st_d      = st_q;
        acc_valid = 1'b0;
        acc_rd    = 1'b0;
        acc_wl    = 1'b0;
        acc_wh    = 1'b0;
        acc_addr  = st_q.base;
        p_go      = ps & ce;
        step      = st_q.cnt + beat_t'(adv);
        if (p_go) begin
            st_d.sel  = 1'b1;
            st_d.base = a;
            st_d.cnt  = '0;
            acc_valid = 1'b1;
            acc_rd    = 1'b1;
            acc_addr  = a;
        end else if (cs) begin
            if (ce) begin
                st_d.sel  = 1'b1;
                st_d.base = a;
                st_d.cnt  = '0;
                acc_valid = 1'b1;
                acc_wl    = wl;
                acc_wh    = wh;
                acc_rd    = ~(wl | wh);
                acc_addr  = a;
            end else begin
                st_d.sel  = 1'b0;
            end
        end else if (st_q.sel) begin
            st_d.cnt  = step;
            acc_valid = 1'b1;
            acc_wl    = wl;
            acc_wh    = wh;
            acc_rd    = ~(wl | wh);
            acc_addr  = {st_q.base[ADDR_W-1:BEAT_W],
                         beat_offset(st_q.base[BEAT_W-1:0], step)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a processor start with chip enable is a plain read
    a_r4_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ps && ce) |-> (acc_valid && acc_rd && !acc_wl && !acc_wh));

    // R5: burst beats stay in the aligned group of the loaded address
    a_r5_same_group: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ps && !cs) |->
            (acc_addr[ADDR_W-1 -: GRP_W] == st_q.base[ADDR_W-1 -: GRP_W]));

    // R9: controller strobe without chip enable makes no access
    a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !ce) |-> !acc_valid);

    // R9: after a deselect, a strobe-free cycle does nothing
    a_r9_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !ce) |=> (!(cs || (ps && ce)) -> !acc_valid));

endmodule

// File: rtl/psb_array.sv
module psb_array #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 18,
    parameter int LO_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              rd,
    input  logic              wl,
    input  logic              wh,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic              rv;
        logic [WORD_W-1:0] dat;
    } out_t;

    logic [WORD_W-1:0] mem [DEPTH];
    out_t              o_d, o_q;

    always_ff @(posedge clk) begin
        if (valid && wl) begin
            mem[addr][LO_W-1:0] <= wdata[LO_W-1:0];
        end
        if (valid && wh) begin
            mem[addr][WORD_W-1:LO_W] <= wdata[WORD_W-1:LO_W];
        end
    end

    always_comb begin
        o_d    = o_q;
        o_d.rv = valid & rd;
        if (valid && rd) begin
            o_d.dat = mem[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rdata  = o_q.dat;
    assign rvalid = o_q.rv;

    // R7: a write cycle leaves the output register untouched
    a_r7_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (wl || wh)) |=> $stable(rdata));

endmodule

// File: rtl/psb_sram.sv
module psb_sram
    import psb_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic              proc_start,
    input  logic              ctrl_start,
    input  logic              advance,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              chip_en,
    input  logic              out_en,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    localparam int LO_W = WORD_W / 2;

    typedef struct packed {
        logic              ps;
        logic              cs;
        logic              adv;
        logic              wl;
        logic              wh;
        logic              ce;
        logic [ADDR_W-1:0] a;
        logic [WORD_W-1:0] d;
    } in_t;

    in_t               in_d, in_q;
    logic              acc_valid, acc_rd, acc_wl, acc_wh;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd_valid;

    always_comb begin
        in_d.ps  = proc_start;
        in_d.cs  = ctrl_start;
        in_d.adv = advance;
        in_d.wl  = wr_lo;
        in_d.wh  = wr_hi;
        in_d.ce  = chip_en;
        in_d.a   = addr;
        in_d.d   = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    psb_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps        (in_q.ps),
        .cs        (in_q.cs),
        .adv       (in_q.adv),
        .wl        (in_q.wl),
        .wh        (in_q.wh),
        .ce        (in_q.ce),
        .a         (in_q.a),
        .acc_valid (acc_valid),
        .acc_rd    (acc_rd),
        .acc_wl    (acc_wl),
        .acc_wh    (acc_wh),
        .acc_addr  (acc_addr)
    );

    psb_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LO_W(LO_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (acc_valid),
        .rd     (acc_rd),
        .wl     (acc_wl),
        .wh     (acc_wh),
        .addr   (acc_addr),
        .wdata  (in_q.d),
        .rdata  (dout),
        .rvalid (rd_valid)
    );

    assign dout_en = out_en & rd_valid;

    // R2: a read access is in the output register one edge later
    a_r2_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_rd) |=> rd_valid);

    // R7: no bus drive after a write cycle
    a_r7_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_wl || acc_wh)) |=> !rd_valid);

    // R1: a captured cycle without any start strobe right after reset does no read
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_valid);

endmodule

// File: tb/sim_psb_sram.sv
module sim_psb_sram;

    localparam int  AW     = 10;
    localparam int  DEPTH  = 1 << AW;
    localparam time PERIOD = 8ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] b_a = '0;
    logic [17:0]   b_d = '0;
    logic          b_ps = 0, b_cs = 0, b_adv = 0, b_wl = 0, b_wh = 0, b_ce = 0;
    logic          b_oe = 1'b1;
    logic [17:0]   dout;
    logic          dout_en;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #(PERIOD/2) clk = ~clk;

    psb_sram #(.ADDR_W(AW), .WORD_W(18)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(b_a), .din(b_d),
        .proc_start(b_ps), .ctrl_start(b_cs), .advance(b_adv),
        .wr_lo(b_wl), .wr_hi(b_wh), .chip_en(b_ce), .out_en(b_oe),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [17:0] pat(int a);
        return 18'((a * 1237 + 77) & 18'h3ffff);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, evaluated at each rising edge
    logic [17:0] ref_mem [DEPTH];
    bit          m_sel = 0;
    int          m_base = 0, m_beat = 0;
    bit          p_v = 0, p_rd = 0, p_wl = 0, p_wh = 0;
    int          p_a = 0;
    logic [17:0] p_d = '0;
    bit          e_rv = 0;
    logic [17:0] e_dat = '0;

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_base = 0; m_beat = 0; p_v = 0; e_rv = 0;
        end else begin
            if (p_v) begin
                if (p_wl) ref_mem[p_a][8:0]  = p_d[8:0];
                if (p_wh) ref_mem[p_a][17:9] = p_d[17:9];
                if (p_rd) e_dat = ref_mem[p_a];
            end
            e_rv = p_v && p_rd;
            p_v = 0; p_rd = 0; p_wl = 0; p_wh = 0; p_d = b_d;
            if (b_ps && b_ce) begin
                m_sel = 1; m_base = int'(b_a); m_beat = 0;
                p_v = 1; p_rd = 1; p_a = m_base;
            end else if (b_cs && !b_ce) begin
                m_sel = 0;
            end else if (b_cs) begin
                m_sel = 1; m_base = int'(b_a); m_beat = 0;
                p_v = 1; p_wl = b_wl; p_wh = b_wh; p_rd = !(b_wl || b_wh);
                p_a = m_base;
            end else if (m_sel) begin
                if (b_adv) m_beat = (m_beat + 1) % 4;
                p_v = 1; p_wl = b_wl; p_wh = b_wh; p_rd = !(b_wl || b_wh);
                p_a = (m_base / 4) * 4 + ((m_base % 4) ^ m_beat);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dout_en === (b_oe && e_rv), "R2 dout_en per clock",
                18'(dout_en), 18'(b_oe && e_rv));
            if (dout_en && !$isunknown(e_dat))
                chk(dout === e_dat, "R2 dout per clock", dout, e_dat);
        end
    end

    // Directed steps; each step's result is checked two steps later
    bit          q1_ck = 0, q2_ck = 0, q1_en = 0, q2_en = 0;
    logic [17:0] q1_v = '0, q2_v = '0;
    string       q1_t = "", q2_t = "";

    task automatic step(input bit ps, cs, adv, wl, wh, ce,
                        input int a, input logic [17:0] d,
                        input bit ck, input bit en, input logic [17:0] ev,
                        input string tag);
        @(negedge clk);
        #1;
        if (q2_ck) begin
            chk(dout_en === q2_en, {q2_t, " dout_en"}, 18'(dout_en), 18'(q2_en));
            if (q2_en) chk(dout === q2_v, {q2_t, " dout"}, dout, q2_v);
        end
        q2_ck = q1_ck; q2_en = q1_en; q2_v = q1_v; q2_t = q1_t;
        q1_ck = ck;    q1_en = en;    q1_v = ev;   q1_t = tag;
        b_ps = ps; b_cs = cs; b_adv = adv; b_wl = wl; b_wh = wh; b_ce = ce;
        b_a = AW'(a); b_d = d;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 1, 0, '0, 0, 0, '0, "");
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dout_en === 1'b0, "R1 reset dout_en", 18'(dout_en), 18'h0);
        rst_n = 1'b1;

        // R3: controller writes of two aligned groups; R7 no drive after write
        for (int i = 0; i < 4; i++)
            step(0, 1, 0, 1, 1, 1, 'h40 + i, pat('h40 + i), 1, 0, '0, "R7 write no drive");
        for (int i = 0; i < 4; i++)
            step(0, 1, 0, 1, 1, 1, 'h80 + i, pat('h80 + i), 1, 0, '0, "R3 ctrl write");

        // R5: bursts from every start offset, five beats to show the wrap
        for (int off = 0; off < 4; off++) begin
            step(1, 0, 0, 0, 0, 1, 'h40 + off, '0, 1, 1, pat('h40 + off), "R5 start beat");
            for (int k = 1; k <= 4; k++)
                step(0, 0, 1, 0, 0, 1, 'h3a5, '0, 1, 1,
                     pat('h40 + (off ^ (k % 4))), "R5 burst beat");
        end

        // R6: no advance holds the word
        step(1, 0, 0, 0, 0, 1, 'h81, '0, 1, 1, pat('h81), "R3 read after write");
        step(0, 0, 0, 0, 0, 1, 'h12, '0, 1, 1, pat('h81), "R6 hold");
        step(0, 0, 0, 0, 0, 1, 'h13, '0, 1, 1, pat('h81), "R6 hold");
        step(0, 0, 0, 0, 0, 1, 'h14, '0, 1, 1, pat('h81), "R6 hold");

        // R8: output enable acts without a clock edge
        @(negedge clk);
        #1;
        b_oe = 1'b0;
        #1;
        chk(dout_en === 1'b0, "R8 oe low", 18'(dout_en), 18'h0);
        b_oe = 1'b1;
        #1;
        chk(dout_en === 1'b1, "R8 oe high", 18'(dout_en), 18'h1);
        chk(dout === pat('h81), "R8 data", dout, pat('h81));

        // R7: independent lanes
        step(0, 1, 0, 1, 0, 1, 'h82, 18'h3ffff, 1, 0, '0, "R7 low lane write");
        step(0, 1, 0, 0, 1, 1, 'h83, 18'h00000, 1, 0, '0, "R7 high lane write");
        step(1, 0, 0, 0, 0, 1, 'h82, '0, 1, 1, {pat('h82)[17:9], 9'h1ff}, "R7 low lane only");
        step(1, 0, 0, 0, 0, 1, 'h83, '0, 1, 1, {9'h000, pat('h83)[8:0]}, "R7 high lane only");

        // R4: processor strobe wins and ignores write enables
        step(1, 1, 0, 1, 1, 1, 'h80, 18'h12345, 1, 1, pat('h80), "R4 priority read");
        step(1, 0, 0, 0, 0, 1, 'h80, '0, 1, 1, pat('h80), "R4 word unchanged");

        // R9: deselect, ignored processor strobe, no writes
        step(0, 1, 0, 0, 0, 0, 'h41, '0, 1, 0, '0, "R9 deselect");
        step(1, 0, 0, 1, 1, 0, 'h41, 18'h0, 1, 0, '0, "R9 ps ignored");
        step(0, 0, 1, 1, 1, 1, 'h41, 18'h0, 1, 0, '0, "R9 idle no write");
        step(1, 0, 0, 0, 0, 1, 'h41, '0, 1, 1, pat('h41), "R9 word unchanged");
        step(1, 0, 0, 0, 0, 1, 'h80, '0, 1, 1, pat('h80), "R9 word unchanged");

        // R1: reset clears selection; a strobe-free write does nothing
        step(0, 1, 0, 1, 1, 1, 0, pat(0), 0, 0, '0, "");
        idle();
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        q1_ck = 0; q2_ck = 0;
        b_ps = 0; b_cs = 0; b_wl = 0; b_wh = 0;
        #1;
        chk(dout_en === 1'b0, "R1 reset clears drive", 18'(dout_en), 18'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 1, 1, 1, 0, 18'h2aaaa, 1, 0, '0, "R1 no write after reset");
        step(1, 0, 0, 0, 0, 1, 0, '0, 1, 1, pat(0), "R1 word unchanged");
        idle();
        idle();
        idle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule